// File: doc/BRIEF.md
# Instruction Fetch Translation Buffer with Refill

This block translates instruction fetch addresses from virtual to physical form. It holds four translation entries and a 6-bit pseudo-LRU state word. Each accepted fetch is first screened. An odd address is rejected. A user-mode fetch in the top eighth of the address space is rejected. Fetches that need no translation pass through with the physical address equal to the virtual one. This covers translation being off and the direct-mapped regions with address bits 31:29 equal to 4, 5 or 7. Every other fetch is compared against all four entries at once.

When no entry matches, the block asks the unified translation table next to it, through a request/response pair. If that table answers with a single match, its entry is written into the slot chosen by the LRU word and the comparison runs again. If it answers with a miss or a multiple match, that result is passed back unchanged. While a fetch is being worked on, `ready` stays low.

Top module: `ifetch_tlb`

## Requirements
- R1: A fetch whose address bit 0 is 1 finishes with status 3 (bad address).
- R2: A user-mode fetch (`req_user`=1) at or above 0xE0000000 finishes with status 3. The same address fetched in privileged mode is passed through.
- R3: When `xlate_en` is 0, or address bits 31:29 are 4, 5 or 7, the fetch finishes with status 0 and `resp_paddr` equal to the address. No unified request is made.
- R4: On a single local match, status is 0 and `resp_paddr` is formed as follows. The page-number part comes from the entry's frame number; the offset part comes from the fetch address. The offset width depends on the size code: 0 gives 1 KB, 1 gives 4 KB, 2 gives 64 KB and 3 gives 1 MB. `resp_valid` is a one-cycle pulse on the second rising edge after acceptance.
- R5: An entry with its shared flag at 0 matches only on an equal ASID. The one exception is a privileged fetch with `single_space`=1, where the ASID is ignored. An entry with the shared flag at 1 matches any ASID.
- R6: On a local miss, one request goes out on `ut_req_valid`. A unified answer of miss (1) or multi-hit (2) finishes the fetch with status 1 or 2, and no local entry changes.
- R7: On a unified hit (0), the returned entry is written into the victim slot and the comparison is retried. `ready` stays 0 from acceptance until the response.
- R8: On a hit of entry e, the LRU word is updated by AND with {0x07,0x39,0x3E,0x3F}[e], then OR with {0x00,0x20,0x14,0x0B}[e]. The victim is chosen by the first of these tests that holds:
  - entry 0 if bits 5:3 are 111;
  - entry 1 if bit 5 is 0 and bits 2:1 are 11;
  - entry 2 if bits 4 and 2 are 0 and bit 0 is 1;
  - entry 3 if bits 3, 1 and 0 are 0;
  - entry 0 otherwise.
  After reset the LRU word is 0.
- R9: A matched entry whose privileged-only flag is 1 gives status 4 (protected) to a user-mode fetch, and status 0 to a privileged one.
- R10: Two or more local matches give status 2.
- R11: `flush` clears the valid flags of all four entries.
- R12: A `flush` in the same cycle as a unified hit takes priority over the entry write. The retry then misses and makes a new unified request.
- R13: Out of reset, `ready` is 1 and `resp_valid` and `ut_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| xlate_en | input | 1 | Translation enable, sampled with the request |
| single_space | input | 1 | Privileged fetches ignore ASID, sampled with the request |
| req_valid | input | 1 | Fetch request, accepted when ready is 1 |
| req_vaddr | input | 32 | Fetch virtual address |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_asid | input | 8 | Current address-space identifier |
| ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_paddr | output | 32 | Physical address |
| resp_status | output | 3 | 0 none, 1 miss, 2 multi-hit, 3 bad address, 4 protected |
| ut_req_valid | output | 1 | Unified lookup request pulse |
| ut_req_vaddr | output | 32 | Address to look up |
| ut_rsp_valid | input | 1 | Unified answer strobe |
| ut_rsp_status | input | 2 | 0 hit, 1 miss, 2 multi-hit |
| ut_rsp_vpn | input | 22 | Entry virtual page number (address bits 31:10) |
| ut_rsp_asid | input | 8 | Entry ASID |
| ut_rsp_ppn | input | 22 | Entry frame number (address bits 31:10) |
| ut_rsp_size | input | 2 | Entry page size code |
| ut_rsp_shared | input | 1 | Entry ignores ASID |
| ut_rsp_priv_only | input | 1 | Entry not usable from user mode |

## Verification
Invalidation and refill writes can fall in the same cycle: a flush pulse can land on the very edge that also writes a unified answer into the victim slot. The bench provokes this by raising `flush` together with `ut_rsp_valid`. It judges the outcome at the ports: a correct design must issue a second unified request for the same fetch and still return the right translation afterwards. Replacement order is judged in the same way, by which pages later force a unified request.

// File: rtl/ifetch_tlb_pkg.sv
package ifetch_tlb_pkg;

  localparam int VA_W   = 32;
  localparam int PG_LSB = 10;
  localparam int VPN_W  = VA_W - PG_LSB;
  localparam int ASID_W = 8;
  localparam int NENT   = 4;
  localparam int IDX_W  = $clog2(NENT);
  localparam int LRU_W  = 6;

  typedef enum logic [2:0] {
    ST_NONE  = 3'd0,
    ST_MISS  = 3'd1,
    ST_MULTI = 3'd2,
    ST_BAD   = 3'd3,
    ST_PROT  = 3'd4
  } xl_status_e;

  typedef enum logic [1:0] {
    UT_HIT   = 2'd0,
    UT_MISS  = 2'd1,
    UT_MULTI = 2'd2
  } ut_status_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  ppn;
    logic [1:0]        size;
    logic              shared;
    logic              priv_only;
  } tlb_ent_t;

  function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    page_mask = ~(VA_W'(1) << 10) + 1'b1;
      2'd1:    page_mask = ~(VA_W'(1) << 12) + 1'b1;
      2'd2:    page_mask = ~(VA_W'(1) << 16) + 1'b1;
      default: page_mask = ~(VA_W'(1) << 20) + 1'b1;
    endcase
  endfunction

  function automatic logic [LRU_W-1:0] lru_keep(input logic [IDX_W-1:0] e);
    case (e)
      2'd0:    lru_keep = 6'h07;
      2'd1:    lru_keep = 6'h39;
      2'd2:    lru_keep = 6'h3E;
      default: lru_keep = 6'h3F;
    endcase
  endfunction

  function automatic logic [LRU_W-1:0] lru_set(input logic [IDX_W-1:0] e);
    case (e)
      2'd0:    lru_set = 6'h00;
      2'd1:    lru_set = 6'h20;
      2'd2:    lru_set = 6'h14;
      default: lru_set = 6'h0B;
    endcase
  endfunction

endpackage

// File: rtl/itlb_lru.sv
module itlb_lru
  import ifetch_tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_idx,
  output logic [IDX_W-1:0] victim
);

  logic [LRU_W-1:0] order_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      order_q <= '0;
    end else if (hit_en) begin
      order_q <= (order_q & lru_keep(hit_idx)) | lru_set(hit_idx);
    end
  end

  always_comb begin
    if (order_q[5:3] == 3'b111) begin
      victim = 2'd0;
    end else if (!order_q[5] && order_q[2:1] == 2'b11) begin
      victim = 2'd1;
    end else if (!order_q[4] && !order_q[2] && order_q[0]) begin
      victim = 2'd2;
    end else if (!order_q[3] && !order_q[1] && !order_q[0]) begin
      victim = 2'd3;
    end else begin
      victim = 2'd0;
    end
  end

  // R8: right after reset the word is zero, which selects slot 3
  p_reset_victim_r8: assert property (@(posedge clk) $fell(rst) |-> victim == 2'd3);

endmodule

// File: rtl/itlb_cam.sv
module itlb_cam
  import ifetch_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  tlb_ent_t          wr_ent,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              lk_user,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_ss,
  output logic              hit_one,
  output logic              hit_many,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              hit_priv_only,
  output logic [VA_W-1:0]   hit_paddr
);

  tlb_ent_t        ent_q [NENT];
  logic [NENT-1:0] vld_q;
  logic [NENT-1:0] hit_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_q[wr_idx] <= wr_ent;
    end
  end

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    logic [VA_W-1:0] msk;
    logic            page_eq;
    logic            need_asid;
    assign msk       = page_mask(ent_q[g].size);
    assign page_eq   = (({ent_q[g].vpn, {PG_LSB{1'b0}}} & msk) == (lk_va & msk));
    assign need_asid = !ent_q[g].shared && (lk_user || !lk_ss);
    assign hit_vec[g] = vld_q[g] && page_eq &&
                        (!need_asid || (ent_q[g].asid == lk_asid));
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NENT; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  logic [VA_W-1:0] sel_msk;
  assign hit_one       = ($countones(hit_vec) == 1);
  assign hit_many      = ($countones(hit_vec) > 1);
  assign sel_msk       = page_mask(ent_q[hit_idx].size);
  assign hit_priv_only = ent_q[hit_idx].priv_only;
  assign hit_paddr     = ({ent_q[hit_idx].ppn, {PG_LSB{1'b0}}} & sel_msk) | (lk_va & ~sel_msk);

  // R11: a flush leaves no valid entry behind
  p_flush_clears_r11: assert property (@(posedge clk) disable iff (rst)
    flush |=> vld_q == '0);

endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb
  import ifetch_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              xlate_en,
  input  logic              single_space,
  input  logic              req_valid,
  input  logic [31:0]       req_vaddr,
  input  logic              req_user,
  input  logic [7:0]        req_asid,
  output logic              ready,
  output logic              resp_valid,
  output logic [31:0]       resp_paddr,
  output logic [2:0]        resp_status,
  output logic              ut_req_valid,
  output logic [31:0]       ut_req_vaddr,
  input  logic              ut_rsp_valid,
  input  logic [1:0]        ut_rsp_status,
  input  logic [21:0]       ut_rsp_vpn,
  input  logic [7:0]        ut_rsp_asid,
  input  logic [21:0]       ut_rsp_ppn,
  input  logic [1:0]        ut_rsp_size,
  input  logic              ut_rsp_shared,
  input  logic              ut_rsp_priv_only
);

  localparam logic [VA_W-1:0] USER_CEIL = 32'hE000_0000;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WAIT} fsm_e;

  fsm_e              state_q;
  logic [VA_W-1:0]   va_q;
  logic              user_q, en_q, ss_q;
  logic [ASID_W-1:0] asid_q;
  xl_status_e        status_q;

  logic odd_addr, user_high, direct_map, screened;
  logic hit_one, hit_many, hit_priv_only;
  logic [IDX_W-1:0] hit_idx, victim;
  logic [VA_W-1:0]  hit_paddr;
  logic             fill_en, lru_touch;
  tlb_ent_t         fill_ent;

  assign odd_addr   = va_q[0];
  assign user_high  = user_q && (va_q >= USER_CEIL);
  assign direct_map = !en_q || (va_q[31:29] == 3'd4) || (va_q[31:29] == 3'd5) ||
                      (va_q[31:29] == 3'd7);
  assign screened   = !odd_addr && !user_high && !direct_map;

  assign fill_en   = (state_q == S_WAIT) && ut_rsp_valid && (ut_rsp_status == UT_HIT);
  assign lru_touch = (state_q == S_CHECK) && screened && hit_one;

  assign fill_ent.vpn       = ut_rsp_vpn;
  assign fill_ent.asid      = ut_rsp_asid;
  assign fill_ent.ppn       = ut_rsp_ppn;
  assign fill_ent.size      = ut_rsp_size;
  assign fill_ent.shared    = ut_rsp_shared;
  assign fill_ent.priv_only = ut_rsp_priv_only;

  itlb_cam u_cam (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .wr_en         (fill_en),
    .wr_idx        (victim),
    .wr_ent        (fill_ent),
    .lk_va         (va_q),
    .lk_user       (user_q),
    .lk_asid       (asid_q),
    .lk_ss         (ss_q),
    .hit_one       (hit_one),
    .hit_many      (hit_many),
    .hit_idx       (hit_idx),
    .hit_priv_only (hit_priv_only),
    .hit_paddr     (hit_paddr)
  );

  itlb_lru u_lru (
    .clk     (clk),
    .rst     (rst),
    .hit_en  (lru_touch),
    .hit_idx (hit_idx),
    .victim  (victim)
  );

  assign ready       = (state_q == S_IDLE);
  assign resp_status = status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      va_q         <= '0;
      user_q       <= 1'b0;
      en_q         <= 1'b0;
      ss_q         <= 1'b0;
      asid_q       <= '0;
      resp_valid   <= 1'b0;
      resp_paddr   <= '0;
      status_q     <= ST_NONE;
      ut_req_valid <= 1'b0;
      ut_req_vaddr <= '0;
    end else begin
      resp_valid   <= 1'b0;
      ut_req_valid <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            va_q    <= req_vaddr;
            user_q  <= req_user;
            asid_q  <= req_asid;
            en_q    <= xlate_en;
            ss_q    <= single_space;
            state_q <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (odd_addr || user_high) begin
            resp_valid <= 1'b1;
            resp_paddr <= '0;
            status_q   <= ST_BAD;
            state_q    <= S_IDLE;
          end else if (direct_map) begin
            resp_valid <= 1'b1;
            resp_paddr <= va_q;
            status_q   <= ST_NONE;
            state_q    <= S_IDLE;
          end else if (hit_many) begin
            resp_valid <= 1'b1;
            resp_paddr <= '0;
            status_q   <= ST_MULTI;
            state_q    <= S_IDLE;
          end else if (hit_one) begin
            resp_valid <= 1'b1;
            state_q    <= S_IDLE;
            if (hit_priv_only && user_q) begin
              resp_paddr <= '0;
              status_q   <= ST_PROT;
            end else begin
              resp_paddr <= hit_paddr;
              status_q   <= ST_NONE;
            end
          end else begin
            ut_req_valid <= 1'b1;
            ut_req_vaddr <= va_q;
            state_q      <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (ut_rsp_valid) begin
            if (ut_rsp_status == UT_HIT) begin
              state_q <= S_CHECK;
            end else begin
              resp_valid <= 1'b1;
              resp_paddr <= '0;
              status_q   <= (ut_rsp_status == UT_MISS) ? ST_MISS : ST_MULTI;
              state_q    <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1: an odd fetch address is rejected on the next edge
  p_odd_bad_r1: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CHECK && va_q[0]) |=> (resp_valid && resp_status == ST_BAD));

  // R3: with translation off, a legal address comes back untouched
  p_bypass_ident_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_CHECK && !en_q && !va_q[0] && !user_high)
      |=> (resp_valid && resp_paddr == $past(va_q) && resp_status == ST_NONE));

  // R4: results are single-cycle pulses
  p_resp_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R7: no new fetch is taken while a unified lookup is outstanding
  p_busy_on_lookup_r7: assert property (@(posedge clk) disable iff (rst)
    ut_req_valid |-> !ready);

  // R6: a unified miss is reported as a miss on the following edge
  p_ut_miss_passes_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_WAIT && ut_rsp_valid && ut_rsp_status == UT_MISS)
      |=> (resp_valid && resp_status == ST_MISS));

endmodule

// File: tb/ifetch_tlb_tb.sv
module ifetch_tlb_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush_a = 1'b0, flush_b = 1'b0;
  logic flush;
  logic xlate_en = 1'b1, single_space = 1'b0;
  logic req_valid = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic ready, resp_valid, ut_req_valid;
  logic [31:0] resp_paddr, ut_req_vaddr;
  logic [2:0]  resp_status;
  logic        ut_rsp_valid = 1'b0;
  logic [1:0]  ut_rsp_status = '0;
  logic [21:0] ut_rsp_vpn = '0, ut_rsp_ppn = '0;
  logic [7:0]  ut_rsp_asid = '0;
  logic [1:0]  ut_rsp_size = '0;
  logic        ut_rsp_shared = 1'b0, ut_rsp_priv_only = 1'b0;

  assign flush = flush_a | flush_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_tlb u_dut (
    .clk(clk), .rst(rst), .flush(flush), .xlate_en(xlate_en),
    .single_space(single_space), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_user(req_user), .req_asid(req_asid), .ready(ready),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_status(resp_status),
    .ut_req_valid(ut_req_valid), .ut_req_vaddr(ut_req_vaddr),
    .ut_rsp_valid(ut_rsp_valid), .ut_rsp_status(ut_rsp_status),
    .ut_rsp_vpn(ut_rsp_vpn), .ut_rsp_asid(ut_rsp_asid), .ut_rsp_ppn(ut_rsp_ppn),
    .ut_rsp_size(ut_rsp_size), .ut_rsp_shared(ut_rsp_shared),
    .ut_rsp_priv_only(ut_rsp_priv_only)
  );

  int checks = 0;
  int failures = 0;

  // unified table model
  logic [21:0] m_vpn [MAXP];
  logic [21:0] m_ppn [MAXP];
  logic [7:0]  m_asid [MAXP];
  logic [1:0]  m_size [MAXP];
  logic        m_sh [MAXP];
  logic        m_po [MAXP];
  int          m_n = 0;
  int          ut_cnt = 0;
  int          force_st = 0;
  bit          flush_on_rsp = 1'b0;
  logic        cur_user = 1'b0, cur_ss = 1'b0;
  logic [7:0]  cur_asid = '0;

  function automatic logic [31:0] pmask(input logic [1:0] s);
    case (s)
      2'd0: pmask = 32'hFFFF_FC00;
      2'd1: pmask = 32'hFFFF_F000;
      2'd2: pmask = 32'hFFFF_0000;
      default: pmask = 32'hFFF0_0000;
    endcase
  endfunction

  task automatic add_page(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                          input logic sh, input logic po, input logic [7:0] asid);
    m_vpn[m_n] = va[31:10]; m_ppn[m_n] = pa[31:10]; m_size[m_n] = sz;
    m_sh[m_n] = sh; m_po[m_n] = po; m_asid[m_n] = asid;
    m_n++;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (ut_req_valid) begin
        int cnt;
        int idx;
        logic [31:0] va;
        ut_cnt++;
        va = ut_req_vaddr;
        cnt = 0; idx = 0;
        for (int i = 0; i < m_n; i++) begin
          logic [31:0] mk;
          logic chk;
          mk  = pmask(m_size[i]);
          chk = !m_sh[i] && (cur_user || !cur_ss);
          if ((({m_vpn[i], 10'b0} & mk) == (va & mk)) && (!chk || m_asid[i] == cur_asid)) begin
            cnt++; idx = i;
          end
        end
        @(negedge clk);
        ut_rsp_valid = 1'b1;
        if (force_st != 0) ut_rsp_status = 2'(force_st);
        else ut_rsp_status = (cnt == 1) ? 2'd0 : (cnt == 0 ? 2'd1 : 2'd2);
        ut_rsp_vpn = m_vpn[idx]; ut_rsp_ppn = m_ppn[idx]; ut_rsp_asid = m_asid[idx];
        ut_rsp_size = m_size[idx]; ut_rsp_shared = m_sh[idx]; ut_rsp_priv_only = m_po[idx];
        if (flush_on_rsp) begin
          flush_b = 1'b1;
          flush_on_rsp = 1'b0;
        end
        @(negedge clk);
        ut_rsp_valid = 1'b0;
        flush_b = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] va, input logic user, input logic [7:0] asid,
                       input logic en, input logic ss,
                       output logic [31:0] pa, output logic [2:0] st,
                       output int lat, output int busy);
    @(negedge clk);
    req_vaddr = va; req_user = user; req_asid = asid; xlate_en = en; single_space = ss;
    cur_user = user; cur_asid = asid; cur_ss = ss;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; busy = 0;
    while (!resp_valid && lat < 60) begin
      if (!ready) busy++;
      @(negedge clk);
      lat++;
    end
    if (!resp_valid) chk(1'b0, "WDOG", "no response", 32'(lat), 32'd0);
    pa = resp_paddr; st = resp_status;
  endtask

  // check a fetch: status, address (if status 0), unified request delta
  task automatic expect_fetch(input string req, input logic [31:0] va, input logic user,
                              input logic [7:0] asid, input logic en, input logic ss,
                              input logic [2:0] exp_st, input logic [31:0] exp_pa,
                              input int exp_ut);
    logic [31:0] pa; logic [2:0] st; int lat; int busy; int u0;
    u0 = ut_cnt;
    fetch(va, user, asid, en, ss, pa, st, lat, busy);
    chk(st == exp_st, req, "status", 32'(st), 32'(exp_st));
    if (exp_st == 3'd0) chk(pa == exp_pa, req, "paddr", pa, exp_pa);
    chk(ut_cnt - u0 == exp_ut, req, "unified requests", 32'(ut_cnt - u0), 32'(exp_ut));
  endtask

  task automatic t_reset;
    chk(ready == 1'b1, "R13", "ready", 32'(ready), 32'd1);
    chk(resp_valid == 1'b0, "R13", "resp_valid", 32'(resp_valid), 32'd0);
    chk(ut_req_valid == 1'b0, "R13", "ut_req_valid", 32'(ut_req_valid), 32'd0);
  endtask

  task automatic t_screen;
    expect_fetch("R1", 32'h0040_0125, 1'b1, 8'd1, 1'b1, 1'b0, 3'd3, 32'h0, 0);
    expect_fetch("R2", 32'hE000_0000, 1'b1, 8'd1, 1'b1, 1'b0, 3'd3, 32'h0, 0);
    expect_fetch("R2", 32'hE000_0000, 1'b0, 8'd1, 1'b1, 1'b0, 3'd0, 32'hE000_0000, 0);
    expect_fetch("R3", 32'h0012_3456, 1'b1, 8'd1, 1'b0, 1'b0, 3'd0, 32'h0012_3456, 0);
    expect_fetch("R3", 32'h8000_1000, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h8000_1000, 0);
    expect_fetch("R3", 32'hA123_4566, 1'b0, 8'd1, 1'b1, 1'b0, 3'd0, 32'hA123_4566, 0);
  endtask

  task automatic t_refill_sizes;
    logic [31:0] pa; logic [2:0] st; int lat; int busy;
    add_page(32'h0040_0000, 32'h0900_0000, 2'd1, 1'b1, 1'b0, 8'd0);
    add_page(32'h0050_0000, 32'h0C00_0000, 2'd3, 1'b1, 1'b0, 8'd0);
    add_page(32'h0060_0400, 32'h0D00_0800, 2'd0, 1'b1, 1'b0, 8'd0);
    add_page(32'h0070_0000, 32'h0E01_0000, 2'd2, 1'b1, 1'b0, 8'd0);
    fetch(32'h0040_0124, 1'b1, 8'd1, 1'b1, 1'b0, pa, st, lat, busy);
    chk(pa == 32'h0900_0124 && st == 3'd0, "R7", "refill result", pa, 32'h0900_0124);
    chk(busy >= 3, "R7", "ready low cycles during refill", 32'(busy), 32'd3);
    fetch(32'h0040_0124, 1'b1, 8'd1, 1'b1, 1'b0, pa, st, lat, busy);
    chk(lat == 2, "R4", "hit latency", 32'(lat), 32'd2);
    chk(pa == 32'h0900_0124, "R4", "4KB paddr", pa, 32'h0900_0124);
    expect_fetch("R4", 32'h005A_BCDE, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0C0A_BCDE, 1);
    expect_fetch("R4", 32'h0060_07FE, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0D00_0BFE, 1);
    expect_fetch("R4", 32'h0070_ABCE, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0E01_ABCE, 1);
  endtask

  // fills went to slots 3,2,1,0; order word is back at zero
  task automatic t_lru;
    add_page(32'h0080_0000, 32'h0F00_0000, 2'd1, 1'b1, 1'b0, 8'd0);
    expect_fetch("R8", 32'h0080_0010, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0F00_0010, 1);
    expect_fetch("R8", 32'h0070_ABCE, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0E01_ABCE, 0);
    expect_fetch("R8", 32'h0040_0124, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0900_0124, 1);
    expect_fetch("R8", 32'h0060_07FE, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0D00_0BFE, 0);
    expect_fetch("R8", 32'h005A_BCDE, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0C0A_BCDE, 1);
  endtask

  task automatic t_prot;
    add_page(32'h0090_0000, 32'h0A00_0000, 2'd1, 1'b1, 1'b1, 8'd0);
    expect_fetch("R9", 32'h0090_0040, 1'b1, 8'd1, 1'b1, 1'b0, 3'd4, 32'h0, 1);
    expect_fetch("R9", 32'h0090_0040, 1'b0, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0A00_0040, 0);
  endtask

  task automatic t_asid;
    @(negedge clk); flush_a = 1'b1; @(negedge clk); flush_a = 1'b0;
    add_page(32'h00A0_0000, 32'h0B00_0000, 2'd1, 1'b0, 1'b0, 8'd5);
    expect_fetch("R5", 32'h00A0_0100, 1'b1, 8'd5, 1'b1, 1'b0, 3'd0, 32'h0B00_0100, 1);
    expect_fetch("R6", 32'h00A0_0100, 1'b1, 8'd6, 1'b1, 1'b0, 3'd1, 32'h0, 1);
    expect_fetch("R5", 32'h00A0_0100, 1'b0, 8'd6, 1'b1, 1'b1, 3'd0, 32'h0B00_0100, 0);
    expect_fetch("R5", 32'h00A0_0100, 1'b0, 8'd6, 1'b1, 1'b0, 3'd1, 32'h0, 1);
  endtask

  task automatic t_ut_multi;
    force_st = 2;
    expect_fetch("R6", 32'h00B0_0000, 1'b1, 8'd5, 1'b1, 1'b0, 3'd2, 32'h0, 1);
    force_st = 0;
    expect_fetch("R6", 32'h00A0_0100, 1'b1, 8'd5, 1'b1, 1'b0, 3'd0, 32'h0B00_0100, 0);
  endtask

  task automatic t_local_multi;
    add_page(32'h00C0_0000, 32'h0100_0000, 2'd1, 1'b0, 1'b0, 8'd1);
    expect_fetch("R10", 32'h00C0_0008, 1'b1, 8'd1, 1'b1, 1'b0, 3'd0, 32'h0100_0008, 1);
    add_page(32'h00C0_0000, 32'h0200_0000, 2'd1, 1'b1, 1'b0, 8'd0);
    expect_fetch("R10", 32'h00C0_0008, 1'b1, 8'd2, 1'b1, 1'b0, 3'd0, 32'h0200_0008, 1);
    expect_fetch("R10", 32'h00C0_0008, 1'b0, 8'd2, 1'b1, 1'b1, 3'd2, 32'h0, 0);
  endtask

  task automatic t_flush;
    @(negedge clk); flush_a = 1'b1; @(negedge clk); flush_a = 1'b0;
    expect_fetch("R11", 32'h00A0_0100, 1'b1, 8'd5, 1'b1, 1'b0, 3'd0, 32'h0B00_0100, 1);
  endtask

  task automatic t_flush_fill;
    add_page(32'h00D0_0000, 32'h0300_0000, 2'd1, 1'b1, 1'b0, 8'd0);
    flush_on_rsp = 1'b1;
    expect_fetch("R12", 32'h00D0_0020, 1'b1, 8'd5, 1'b1, 1'b0, 3'd0, 32'h0300_0020, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_screen();
    t_refill_sizes();
    t_lru();
    t_prot();
    t_asid();
    t_ut_multi();
    t_local_multi();
    t_flush();
    t_flush_fill();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL WDOG watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule